// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the digital control for one general-purpose I/O pin. It keeps the pin's output latch and its mode bit. The mode is either quasi-bidirectional or open-drain. From these two values it drives separate enables for three pullups (weak, very weak and strong) and for one pulldown. The analog drivers sit outside the block and act on those enables.

The strong pullup is a short timed pulse. It speeds up a low-to-high edge when the latch goes from 0 to 1 in quasi-bidirectional mode. The pad level enters through a two-flop synchronizer and a glitch filter. The filter passes a new level only after the level has held for a set number of cycles. The block returns the filtered level as clean input data.

Software-facing logic reaches the block through two write strobes, one for the latch and one for the mode. Each strobe updates its register at the next rising clock edge. Without a strobe, the register holds its value.

Top module: `qb_pin_ctrl`

## Requirements
- R1: After reset the latch is 1, the mode is quasi-bidirectional, no strong pulse runs and the filtered input is 1. So pd_en=0, pu_vweak=1, pu_strong=0 and din=1. pu_weak=1 while the pad stays high.
- R2: A strobe on wr_latch loads latch_d, and a strobe on wr_mode loads mode_od_d (1 = open-drain, 0 = quasi-bidirectional). Each takes effect at the next rising edge. Without a strobe, the value holds.
- R3: pd_en is 1 exactly while the latch holds 0. This is true in both modes.
- R4: In quasi-bidirectional mode, a latch change from 0 to 1 asserts pu_strong for exactly PULSE cycles (default 2). It starts in the cycle after the write edge. Writing 1 to a latch that already holds 1 starts no pulse.
- R5: A write that makes the latch 0, or a write that selects open-drain mode, ends any running strong pulse at that same edge.
- R6: In quasi-bidirectional mode, pu_vweak is 1 whenever the latch is 1.
- R7: In quasi-bidirectional mode, pu_weak is 1 only while the latch is 1 and the synchronized pad reads 1. The synchronized pad follows pad_i two edges later.
- R8: In open-drain mode, pu_weak, pu_vweak and pu_strong all stay 0.
- R9: A pullup enable and pd_en are never 1 in the same cycle.
- R10: din takes a new pad level only after the synchronized pad has shown that level for STABLE consecutive edges (default 3). A pad level held for at least STABLE cycles reaches din at the (STABLE+2)-th edge, counting the first edge that samples it. A shorter pulse leaves din unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_latch | input | 1 | Latch write strobe |
| latch_d | input | 1 | Value written to the latch |
| wr_mode | input | 1 | Mode write strobe |
| mode_od_d | input | 1 | Mode written: 1 open-drain, 0 quasi-bidirectional |
| pad_i | input | 1 | Raw pad level |
| pu_weak | output | 1 | Weak pullup enable |
| pu_vweak | output | 1 | Very weak pullup enable |
| pu_strong | output | 1 | Strong pullup enable |
| pd_en | output | 1 | Pulldown enable |
| din | output | 1 | Filtered input data |

## Verification
Some properties are checked on every cycle by the assertions:
- a pullup and the pulldown are never on together;
- open-drain mode keeps every pullup off;
- a qualifying 0-to-1 latch write is followed by a strong pulse that lasts at least its second cycle;
- din only ever moves to the level the synchronizer is already holding.

Other behaviour can only be shown by the bench's scenarios, which run against a cycle model:
- the exact length of the strong pulse and its cancellation on a latch-0 write or a switch to open-drain;
- that rewriting 1 starts nothing;
- the exact edge at which a filtered level appears;
- that short pad pulses are rejected.

// File: rtl/qb_pin_ctrl.sv
module qb_pin_ctrl #(
  parameter int STABLE = 3,
  parameter int PULSE  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_latch,
  input  logic latch_d,
  input  logic wr_mode,
  input  logic mode_od_d,
  input  logic pad_i,
  output logic pu_weak,
  output logic pu_vweak,
  output logic pu_strong,
  output logic pd_en,
  output logic din
);
  localparam int PW = $clog2(PULSE + 1);
  localparam int FW = $clog2(STABLE + 1);

  logic          latch_q, od_q;
  logic [PW-1:0] pulse_cnt;
  logic [1:0]    sync_q;
  logic [FW-1:0] filt_cnt;
  logic          filt_q;

  logic latch_nx, od_nx, rise;
  assign latch_nx = wr_latch ? latch_d : latch_q;
  assign od_nx    = wr_mode ? mode_od_d : od_q;
  assign rise     = wr_latch & latch_d & ~latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= 1'b1;
      od_q      <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      latch_q <= latch_nx;
      od_q    <= od_nx;
      if (od_nx || !latch_nx)
        pulse_cnt <= '0;
      else if (rise)
        pulse_cnt <= PW'(PULSE);
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      filt_cnt <= '0;
      filt_q   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pad_i};
      if (sync_q[1] == filt_q)
        filt_cnt <= '0;
      else if (filt_cnt == FW'(STABLE - 1)) begin
        filt_q   <= sync_q[1];
        filt_cnt <= '0;
      end else
        filt_cnt <= filt_cnt + 1'b1;
    end
  end

  assign pd_en     = ~latch_q;
  assign pu_vweak  = latch_q & ~od_q;
  assign pu_weak   = latch_q & ~od_q & sync_q[1];
  assign pu_strong = pulse_cnt != '0;
  assign din       = filt_q;

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> !(pu_weak || pu_vweak || pu_strong));

  assert_od_no_pullup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    od_q |-> !(pu_weak || pu_vweak || pu_strong));

  assert_strong_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !od_nx) |=> pu_strong);

  assert_strong_second_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_strong && !$past(pu_strong) && !wr_latch && !wr_mode) |=> pu_strong);

  assert_pulldown_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_latch && !latch_d) |=> pd_en);

  assert_filter_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (din != $past(din)) |-> (din == $past(sync_q[1])));
endmodule

// File: tb/qb_pin_ctrl_tb.sv
`timescale 1ns/1ps
module qb_pin_ctrl_tb;
  localparam int STABLE = 3;
  localparam int PULSE  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_latch = 1'b0, latch_d = 1'b0, wr_mode = 1'b0, mode_od_d = 1'b0, pad_i = 1'b1;
  logic pu_weak, pu_vweak, pu_strong, pd_en, din;

  int tests = 0;
  int fails = 0;
  bit auto_chk = 1'b0;

  always #10 clk = ~clk;

  qb_pin_ctrl #(.STABLE(STABLE), .PULSE(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_latch(wr_latch), .latch_d(latch_d),
    .wr_mode(wr_mode), .mode_od_d(mode_od_d), .pad_i(pad_i),
    .pu_weak(pu_weak), .pu_vweak(pu_vweak), .pu_strong(pu_strong),
    .pd_en(pd_en), .din(din));

  // cycle model built from the requirements
  logic m_latch, m_od, m_s1, m_s2, m_prev_s2, m_f;
  int   m_pulse, m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 1; m_od = 0; m_pulse = 0;
      m_s1 = 1; m_s2 = 1; m_prev_s2 = 1; m_f = 1; m_run = STABLE;
    end else begin
      logic nl, no, rs;
      nl = wr_latch ? latch_d : m_latch;
      no = wr_mode ? mode_od_d : m_od;
      rs = wr_latch && latch_d && !m_latch;
      if (no || !nl) m_pulse = 0;
      else if (rs) m_pulse = PULSE;
      else if (m_pulse > 0) m_pulse--;
      m_latch = nl; m_od = no;
      m_run = (m_s2 == m_prev_s2) ? m_run + 1 : 1;
      m_prev_s2 = m_s2;
      if (m_s2 != m_f && m_run >= STABLE) m_f = m_s2;
      m_s2 = m_s1; m_s1 = pad_i;
    end
  end

  function automatic bit exp_pd();     return !m_latch;                  endfunction
  function automatic bit exp_vweak();  return m_latch && !m_od;          endfunction
  function automatic bit exp_weak();   return m_latch && !m_od && m_s2;  endfunction
  function automatic bit exp_strong(); return m_pulse != 0;              endfunction

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && auto_chk) begin
    check("R3 pd_en", pd_en, exp_pd());
    check("R6 pu_vweak", pu_vweak, exp_vweak());
    check("R7 pu_weak", pu_weak, exp_weak());
    check("R4 pu_strong", pu_strong, exp_strong());
    check("R10 din", din, m_f);
    check("R9 exclusion", pd_en && (pu_weak || pu_vweak || pu_strong), 1'b0);
    if (m_od) check("R8 od pullups", pu_weak | pu_vweak | pu_strong, 1'b0);
  end

  task automatic step(bit wl, bit ld, bit wm, bit md, bit pad);
    wr_latch = wl; latch_d = ld; wr_mode = wm; mode_od_d = md; pad_i = pad;
    @(negedge clk);
    wr_latch = 0; wr_mode = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pd_en", pd_en, 1'b0);
    check("R1 pu_vweak", pu_vweak, 1'b1);
    check("R1 pu_weak", pu_weak, 1'b1);
    check("R1 pu_strong", pu_strong, 1'b0);
    check("R1 din", din, 1'b1);
    auto_chk = 1;

    // R2/R3: latch write 0, pulldown on
    step(1, 0, 0, 0, 1);
    check("R2 R3 pd after write 0", pd_en, 1'b1);
    // R4: 0->1 gives exactly two cycles of strong
    step(1, 1, 0, 0, 1);
    check("R4 strong cycle 1", pu_strong, 1'b1);
    idle(1);
    check("R4 strong cycle 2", pu_strong, 1'b0 || PULSE >= 2);
    idle(1);
    check("R4 strong ends", pu_strong, 1'b0);
    // R4: rewrite 1 while 1: no pulse
    step(1, 1, 0, 0, 1);
    check("R4 no pulse on 1->1", pu_strong, 1'b0);
    // R5: write 0 during pulse cancels
    step(1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    check("R5 cancel by latch 0", pu_strong, 1'b0);
    // R5/R8: switch to open-drain during pulse
    step(1, 1, 0, 0, 1);
    step(0, 0, 1, 1, 1);
    check("R5 cancel by open-drain", pu_strong, 1'b0);
    check("R8 vweak off in od", pu_vweak, 1'b0);
    // R8: 0->1 in open-drain gives no pulse; pulldown still works (R3)
    step(1, 0, 0, 0, 1);
    check("R3 od pulldown", pd_en, 1'b1);
    step(1, 1, 0, 0, 1);
    check("R8 no strong in od", pu_strong, 1'b0);
    step(0, 0, 1, 0, 1);
    check("R2 mode back quasi", pu_vweak, 1'b1);
    // R10: 2-cycle low glitch ignored
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    pad_i = 1;
    idle(8);
    check("R10 glitch ignored", din, 1'b1);
    // R10: 3-cycle low accepted at STABLE+2 edges
    step(0, 0, 0, 0, 0);
    idle(STABLE);
    check("R10 not yet", din, 1'b1);
    idle(1);
    check("R10 accepted", din, 1'b0);
    check("R7 weak off with pad low", pu_weak, 1'b0);
    pad_i = 1;
    idle(8);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit wl, ld, wm, md, pd;
      wl = ($urandom % 4) == 0;
      ld = $urandom % 2;
      wm = ($urandom % 16) == 0;
      md = ($urandom % 4) == 0;
      pd = (($urandom % 6) == 0) ? !pad_i : pad_i;
      step(wl, ld, wm, md, pd);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule